// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block forms the byte a memory device returns on a read while an internal program or erase operation is running. The bus front end sends it a start event with the operation kind and the data byte written by the final command write. It sends an end event when the internal operation finishes. On every read access it also supplies a strobe and a flag saying whether the read address lies in the area being worked on. The block returns either array data or a status byte. In the status byte, the top bit is a polling bit whose polarity depends on the operation, and bit 6 flips on each read.

The polling bit lets the host wait until the operation ends: a program reports the inverse of the written top bit, and an erase reports zero. The toggle bit lets the host detect activity at any address, because two reads in a row differ while the device is busy. Once the end event has been taken, every read returns plain array data. A start event that arrives while an operation is already running is dropped.

Top module: `op_status_reporter`

## Requirements
- R1: While a program is busy and `in_region` is high, `rd_data[7]` is the inverse of bit 7 of the `wr_data` byte captured with the accepted start.
- R2: While an erase is busy (`op_kind` = 1 at start; 0 means program) and `in_region` is high, `rd_data[7]` is 0.
- R3: While busy, each cycle with `rd_strobe` high inverts `rd_data[6]` from the next cycle onward, whatever the value of `in_region`.
- R4: While busy, a cycle without `rd_strobe` leaves `rd_data[6]` unchanged in the next cycle.
- R5: A start accepted while idle makes the block busy from the next cycle, and `rd_data[6]` then begins at 0.
- R6: While busy and `in_region` is high, `rd_data[5:0]` is 0.
- R7: While busy and `in_region` is low, `rd_data[7]` and `rd_data[5:0]` equal the matching bits of `array_data`, while `rd_data[6]` still shows the toggle bit.
- R8: When idle, including from the cycle after `op_done`, `rd_data` equals `array_data`, and `rd_strobe` has no effect.
- R9: An `op_start` seen while busy is ignored: it changes neither the operation kind, nor the captured bit, nor the toggle bit.
- R10: While `rst_n` is low and after it is released, the block is idle and `rd_data` equals `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_start | input | 1 | Pulse: internal operation begins |
| op_kind | input | 1 | Kind sampled with op_start: 0 program, 1 erase |
| wr_data | input | 8 | Byte written by the final command write |
| op_done | input | 1 | Pulse: internal operation has finished |
| rd_strobe | input | 1 | One pulse per read access (chip or output enable) |
| in_region | input | 1 | Read address lies inside the area being operated on |
| array_data | input | 8 | Byte read from the array at the current address |
| rd_data | output | 8 | Byte presented to the data bus |

## Verification
The vector walk runs a program whose written top bit is 0, so its polling bit reads 1. An erase polls 0. This lets a check tell which operation kind the block thinks is running, and it exposes a start that was wrongly accepted during a busy period. Reads with `in_region` high and low are interleaved with the array byte set to patterns unlike the status, which separates status bits from passed-through bits. Strobed and unstrobed busy cycles check that the toggle follows reads and not clock cycles, and idle strobes check that it stops. A reset in the middle of an operation checks that the block returns to idle.

// File: rtl/op_status_pkg.sv
package op_status_pkg;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_e;

    typedef struct packed {
        logic     busy;
        op_kind_e kind;
        logic     ref_bit;
    } track_state_t;

endpackage

// File: rtl/op_tracker.sv
module op_tracker
    import op_status_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     op_start,
    input  logic     op_kind,
    input  logic     wr_bit,
    input  logic     op_done,
    output logic     busy,
    output op_kind_e kind,
    output logic     ref_bit,
    output logic     accept
);

    track_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        if (st_q.busy) begin
            if (op_done) begin
                st_d.busy = 1'b0;
            end
        end else if (op_start) begin
            accept       = 1'b1;
            st_d.busy    = 1'b1;
            st_d.kind    = op_kind_e'(op_kind);
            st_d.ref_bit = wr_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, kind: OP_PROGRAM, ref_bit: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign kind    = st_q.kind;
    assign ref_bit = st_q.ref_bit;

endmodule

// File: rtl/toggle_gen.sv
module toggle_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic busy,
    input  logic rd_strobe,
    output logic tog
);

    logic tog_d, tog_q;

    always_comb begin
        tog_d = tog_q;
        if (clear) begin
            tog_d = 1'b0;
        end else if (busy && rd_strobe) begin
            tog_d = ~tog_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else begin
            tog_q <= tog_d;
        end
    end

    assign tog = tog_q;

endmodule

// File: rtl/status_mux.sv
module status_mux
    import op_status_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic              busy,
    input  op_kind_e          kind,
    input  logic              ref_bit,
    input  logic              tog,
    input  logic              in_region,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);

    logic show_status;
    logic poll_val;

    assign show_status = busy && in_region;
    assign poll_val    = (kind == OP_PROGRAM) ? ~ref_bit : 1'b0;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == POLL_BIT) begin : g_poll
            assign rd_data[b] = show_status ? poll_val : array_data[b];
        end else if (b == TOG_BIT) begin : g_tog
            assign rd_data[b] = busy ? tog : array_data[b];
        end else begin : g_fill
            assign rd_data[b] = show_status ? 1'b0 : array_data[b];
        end
    end

endmodule

// File: rtl/op_status_reporter.sv
module op_status_reporter
    import op_status_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int POLL_BIT = DATA_W - 1,
    parameter int TOG_BIT  = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_kind,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              op_done,
    input  logic              rd_strobe,
    input  logic              in_region,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);

    logic     busy_w;
    op_kind_e kind_w;
    logic     ref_w;
    logic     accept_w;
    logic     tog_w;

    op_tracker u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (op_start),
        .op_kind  (op_kind),
        .wr_bit   (wr_data[POLL_BIT]),
        .op_done  (op_done),
        .busy     (busy_w),
        .kind     (kind_w),
        .ref_bit  (ref_w),
        .accept   (accept_w)
    );

    toggle_gen u_tog (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept_w),
        .busy      (busy_w),
        .rd_strobe (rd_strobe),
        .tog       (tog_w)
    );

    status_mux #(
        .DATA_W   (DATA_W),
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT)
    ) u_mux (
        .busy       (busy_w),
        .kind       (kind_w),
        .ref_bit    (ref_w),
        .tog        (tog_w),
        .in_region  (in_region),
        .array_data (array_data),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/op_status_checker.sv
module op_status_checker
    import op_status_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int POLL_BIT = DATA_W - 1,
    parameter int TOG_BIT  = DATA_W - 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_start,
    input logic              op_kind,
    input logic [DATA_W-1:0] wr_data,
    input logic              op_done,
    input logic              rd_strobe,
    input logic              in_region,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              busy_w,
    input op_kind_e          kind_w
);

    AST_PROG_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !busy_w && op_kind == 1'b0) |=>
            (!in_region || rd_data[POLL_BIT] == ~$past(wr_data[POLL_BIT]))); // R1

    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && kind_w == OP_ERASE && in_region) |-> !rd_data[POLL_BIT]); // R2

    AST_TOGGLE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && rd_strobe && !op_done) |=> (rd_data[TOG_BIT] != $past(rd_data[TOG_BIT]))); // R3

    AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && !rd_strobe && !op_done) |=> $stable(rd_data[TOG_BIT])); // R4

    AST_START_CLEARS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !busy_w) |=> (busy_w && !rd_data[TOG_BIT])); // R5

    AST_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && in_region) |-> (rd_data[TOG_BIT-1:0] == '0)); // R6

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_w |-> (rd_data == array_data)); // R8

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && op_start && !op_done) |=> (busy_w && $stable(kind_w))); // R9

endmodule

bind op_status_reporter op_status_checker #(
    .DATA_W   (DATA_W),
    .POLL_BIT (POLL_BIT),
    .TOG_BIT  (TOG_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_start   (op_start),
    .op_kind    (op_kind),
    .wr_data    (wr_data),
    .op_done    (op_done),
    .rd_strobe  (rd_strobe),
    .in_region  (in_region),
    .array_data (array_data),
    .rd_data    (rd_data),
    .busy_w     (busy_w),
    .kind_w     (kind_w)
);

// File: tb/op_status_reporter_tb.sv
module op_status_reporter_tb;

    localparam int PERIOD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start = 1'b0;
    logic       op_kind = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       op_done = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       in_region = 1'b0;
    logic [7:0] array_data = 8'h00;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    op_status_reporter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_start   (op_start),
        .op_kind    (op_kind),
        .wr_data    (wr_data),
        .op_done    (op_done),
        .rd_strobe  (rd_strobe),
        .in_region  (in_region),
        .array_data (array_data),
        .rd_data    (rd_data)
    );

    // s: start, k: kind (1 erase), w: written byte, d: done, r: read strobe,
    // g: in region, a: array byte, e: expected rd_data in that cycle, q: requirement
    typedef struct packed {
        logic       s;
        logic       k;
        logic [7:0] w;
        logic       d;
        logic       r;
        logic       g;
        logic [7:0] a;
        logic [7:0] e;
        logic [7:0] q;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h3C, 8'h3C, 8'd8}, // R8 idle pass
        '{1'b1, 1'b0, 8'h25, 1'b0, 1'b0, 1'b1, 8'h3C, 8'h3C, 8'd5}, // R5 start program
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h80, 8'd1}, // R1 R6 R5
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h80, 8'd1}, // R1 read
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hC0, 8'd3}, // R3 flipped
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hC0, 8'd4}, // R4 hold
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h01, 8'h41, 8'd7}, // R7 outside
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 8'h01, 8'd3}, // R3 any address
        '{1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h80, 8'd9}, // R9 erase start while busy
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h80, 8'd9}, // R9 kind kept
        '{1'b1, 1'b0, 8'h80, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hC0, 8'd3}, // R3 start while busy
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'hFF, 8'hC0, 8'd9}, // R9 toggle kept
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h5A, 8'h5A, 8'd8}, // R8 after done
        '{1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h5A, 8'h5A, 8'd8}, // R8 strobe ignored
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, 8'd2}, // R2 erase poll
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h40, 8'd2}, // R2 R3
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h00, 8'd3}, // R3 back to 0
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hBF, 8'd7}, // R7 erase outside
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hFF, 8'd8}  // R8 erase complete
    };

    task automatic check(input logic [7:0] exp, input int req, input string what);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL R%0d %s: rd_data=%h expected=%h", req, what, rd_data, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_start   = v.s;
        op_kind    = v.k;
        wr_data    = v.w;
        op_done    = v.d;
        rd_strobe  = v.r;
        in_region  = v.g;
        array_data = v.a;
    endtask

    task automatic idle_inputs();
        op_start  = 1'b0;
        op_done   = 1'b0;
        rd_strobe = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R10: outputs during reset
        array_data = 8'hA7;
        in_region  = 1'b1;
        #(PERIOD * 3 + 1);
        check(8'hA7, 10, "during reset");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(8'hA7, 10, "after reset release");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #1;
            check(VECS[i].e, int'(VECS[i].q), $sformatf("vector %0d", i));
        end

        // R10: reset in the middle of a program returns to idle
        @(negedge clk);
        idle_inputs();
        op_start = 1'b1;
        op_kind  = 1'b0;
        wr_data  = 8'h00;
        in_region = 1'b1;
        array_data = 8'h12;
        @(negedge clk);
        op_start = 1'b0;
        #1;
        check(8'h80, 1, "program of bit 0 polls 1");
        rst_n = 1'b0;
        #1;
        check(8'h12, 10, "reset mid operation");
        @(negedge clk);
        rst_n = 1'b1;
        rd_strobe = 1'b1;
        #1;
        check(8'h12, 10, "idle after mid-op reset");
        @(negedge clk);
        rd_strobe = 1'b0;
        #1;
        check(8'h12, 8, "strobe while idle has no effect");

        // R5: fresh start after a strobed run begins toggle at 0
        @(negedge clk);
        op_start = 1'b1;
        op_kind  = 1'b1;
        @(negedge clk);
        op_start  = 1'b0;
        rd_strobe = 1'b1;
        #1;
        check(8'h00, 5, "erase start toggle 0");
        @(negedge clk);
        rd_strobe = 1'b0;
        op_done   = 1'b1;
        #1;
        check(8'h40, 3, "toggle after one read");
        @(negedge clk);
        op_done = 1'b0;
        @(negedge clk);
        op_start = 1'b1;
        op_kind  = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        #1;
        check(8'h00, 5, "toggle cleared by new start");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule